// File: doc/BRIEF.md
# Bus Cycle Sequencer for a Handshaked Memory Bus

This block runs single memory cycles on behalf of an internal DMA-style client on a bus that ends each cycle with a slave handshake. The handshake is either a two-bit asynchronous acknowledge or a one-bit synchronous terminate. The client raises a request with an address, a direction and write data. The sequencer accepts it when idle, takes the bus through one T1 state and one or more T2 states, and returns with a one-clock done pulse. For reads, the done pulse carries the captured data.

All timing is kept on a single fast clock `clk` that runs at twice the bus clock. A registered phase bit splits each bus clock into a high half and a low half, and the bus clock itself is output as `bclk`. A rising bus edge is the `clk` edge that enters the high half. A falling bus edge is the `clk` edge that enters the low half. The handshake inputs pass through a two-flop synchronizer on `clk` before they are used.

Both strobes are active low. `rd_wr` is 1 for a read. In the timings below, t counts `clk` cycles after the edge that raises `ack` (t=0), and k is the count of `clk` edges between that edge and the point where the slave drives the handshake low.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held and just after it, `as_n` and `ds_n` are 1, and `bus_doe`, `ack` and `done` are 0.
- R2: A request is accepted only in idle, at a rising bus edge. `ack` is a one-clock pulse. A request held during an active cycle is not acknowledged again until that cycle has finished.
- R3: A read asserts `as_n` and `ds_n` together at the falling bus edge inside T1 (t=1).
- R4: A write drives `bus_dout` with the write data and raises `bus_doe` from the start of T1 (t=0). `ds_n` stays 1 for a write with no wait state. With wait states, `ds_n` falls at the falling edge of the first T2 (t=3).
- R5: The asynchronous acknowledge terminates when either `dsack_n` bit is low. It is checked at each rising bus edge that starts a T2, after synchronization. The cycle then has n = (k+2)/2 wait states (integer division), or n = 0 if the handshake is already low before the request.
- R6: The synchronous terminate is checked at each falling bus edge inside T2, after synchronization. The cycle then has n = (k+1)/2 wait states, or n = 0 if the handshake is already low before the request.
- R7: At the falling edge of the last T2 (t=3+2n), `as_n` and `ds_n` return to 1 and `bus_doe` drops. At the same time `done` pulses for exactly one clock. For a read, `rdata` then holds the value on `bus_din` at that edge.
- R8: `rd_wr` equals the request's direction and stays stable for as long as `as_n` is 0.
- R9: After a cycle ends, the earliest next T1 starts one `clk` later (half a bus clock). `bus_doe` is therefore 0 for at least one clock between back-to-back writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Client request |
| req_rd | input | 1 | Request direction, 1 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| ack | output | 1 | One-clock request accept pulse |
| done | output | 1 | One-clock cycle complete pulse |
| rdata | output | DW | Read data, valid with done |
| bclk | output | 1 | Bus clock derived from phase |
| bus_addr | output | AW | Bus address |
| bus_dout | output | DW | Bus write data |
| bus_doe | output | 1 | Bus data output enable |
| bus_din | input | DW | Bus read data |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rd_wr | output | 1 | Cycle direction, 1 = read |
| dsack_n | input | 2 | Asynchronous acknowledge, active low |
| sterm_n | input | 1 | Synchronous terminate, active low |

## Verification
The bench sweeps both directions and both termination styles. For each, it places the handshake before the request and at every clock offset from 0 to 6, so both parity cases of the synchronizer delay and the two-clock early-termination case are covered. A design that counts the synchronizer latency wrongly ends one bus clock early or late, and the done time catches it. A zero-wait write that pulses `ds_n` fails the strobe check, and a read that captures data one edge off returns the wrong `rdata`. A back-to-back test holds the request high. A design that accepts a request while busy, or that overlaps the data enable across the cycle boundary, shows an extra `ack` or a missing half-clock gap in `bus_doe`.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          bclk,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  output logic          as_n,
  output logic          ds_n,
  output logic          rd_wr,
  input  logic [1:0]    dsack_n,
  input  logic          sterm_n
);

  typedef enum logic [1:0] {S_IDLE, S_T1, S_T2} st_t;

  st_t        st;
  logic       ph, as_q, ds_q, last, rd_q;
  logic [1:0] dsk_s1, dsk_s2;
  logic       stm_s1, stm_s2;

  wire dsk_hit = ~&dsk_s2;
  wire stm_hit = ~stm_s2;
  wire start   = (st == S_IDLE) && ph && req;
  wire fin     = (st == S_T2) && !ph && (last || stm_hit);

  assign bclk  = ~ph;
  assign as_n  = ~as_q;
  assign ds_n  = ~ds_q;
  assign rd_wr = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsk_s1 <= '1;
      dsk_s2 <= '1;
      stm_s1 <= 1'b1;
      stm_s2 <= 1'b1;
    end else begin
      dsk_s1 <= dsack_n;
      dsk_s2 <= dsk_s1;
      stm_s1 <= sterm_n;
      stm_s2 <= stm_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= 1'b0;
      as_q     <= 1'b0;
      ds_q     <= 1'b0;
      last     <= 1'b0;
      rd_q     <= 1'b1;
      ack      <= 1'b0;
      done     <= 1'b0;
      bus_doe  <= 1'b0;
      bus_addr <= '0;
      bus_dout <= '0;
      rdata    <= '0;
    end else begin
      ph   <= ~ph;
      ack  <= start;
      done <= fin;
      case (st)
        S_IDLE: if (start) begin
          st       <= S_T1;
          rd_q     <= req_rd;
          bus_addr <= req_addr;
          bus_dout <= req_wdata;
          bus_doe  <= ~req_rd;
        end
        S_T1: if (!ph) begin
          as_q <= 1'b1;
          ds_q <= rd_q;
        end else begin
          st   <= S_T2;
          last <= dsk_hit;
        end
        S_T2: if (!ph) begin
          if (fin) begin
            st      <= S_IDLE;
            as_q    <= 1'b0;
            ds_q    <= 1'b0;
            bus_doe <= 1'b0;
            if (rd_q) rdata <= bus_din;
          end else if (!rd_q) begin
            ds_q <= 1'b1;
          end
        end else begin
          last <= dsk_hit;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module bus_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ack,
  input logic done,
  input logic as_n,
  input logic ds_n,
  input logic bus_doe,
  input logic rd_wr
);

  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);

  // R2
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |-> as_n && ds_n);

  // R3
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_n) && rd_wr |-> !ds_n);

  // R4
  write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_n) && !rd_wr |-> ds_n);

  // R7
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> as_n && ds_n && !bus_doe);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R8
  rw_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n && $past(!as_n) |-> $stable(rd_wr));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .done(done),
  .as_n(as_n), .ds_n(ds_n), .bus_doe(bus_doe), .rd_wr(rd_wr)
);

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_rd = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0, bus_din = '0;
  logic        ack, done, bclk, bus_doe, as_n, ds_n, rd_wr;
  logic [31:0] rdata, bus_addr, bus_dout;
  logic [1:0]  dsack_n = 2'b11;
  logic        sterm_n = 1'b1;
  int total = 0, bad = 0, seq = 0;

  always #10 clk = ~clk;

  bus_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .done(done), .rdata(rdata), .bclk(bclk),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .as_n(as_n), .ds_n(ds_n), .rd_wr(rd_wr), .dsack_n(dsack_n), .sterm_n(sterm_n)
  );

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic hs(input bit stm, input bit one_bit, input bit v);
    if (stm) sterm_n = v;
    else dsack_n = v ? 2'b11 : (one_bit ? 2'b10 : 2'b00);
  endtask

  task automatic xfer(input bit rd, input bit stm, input int k);
    logic [31:0] a, w, d;
    int n, as_t, ds_t, done_t, g;
    bit doe_ok, rw_ok, rel_ok, extra;
    seq++;
    a = 32'h1000_0000 + seq * 4;
    w = 32'hA500_0000 ^ (seq * 32'h0001_0203);
    d = 32'h5A00_0000 ^ (seq * 32'h0302_0100);
    req_addr = a; req_wdata = w; bus_din = d; req_rd = rd;
    if (k < 0) begin
      hs(stm, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
    end
    req = 1'b1;
    g = 0;
    do begin @(negedge clk); g++; end while (!ack && g < 40);
    chk(ack, "R2 ack", ack, 1);
    req = 1'b0;
    chk(bus_addr == a, "R4 addr", bus_addr, a);
    chk(rd_wr == rd, "R8 dir", rd_wr, rd);
    chk(bus_doe == !rd, "R4 doe at T1", bus_doe, !rd);
    if (!rd) chk(bus_dout == w, "R4 wdata", bus_dout, w);
    if (k == 0) hs(stm, seq[0], 1'b0);
    as_t = -1; ds_t = -1; done_t = -1;
    doe_ok = 1; rw_ok = 1; rel_ok = 1; extra = 0;
    for (int t = 1; t < 80 && done_t < 0; t++) begin
      @(negedge clk);
      if (ack) extra = 1;
      if (!as_n && as_t < 0) as_t = t;
      if (!ds_n && ds_t < 0) ds_t = t;
      if (!as_n && rd_wr != rd) rw_ok = 0;
      if (done) begin
        done_t = t;
        if (!as_n || !ds_n || bus_doe) rel_ok = 0;
      end else if (bus_doe != !rd) doe_ok = 0;
      if (t == k) hs(stm, seq[0], 1'b0);
    end
    if (k < 0) n = 0;
    else if (stm) n = (k + 1) / 2;
    else n = (k + 2) / 2;
    if (stm) chk(done_t == 3 + 2 * n, "R6 end time", done_t, 3 + 2 * n);
    else chk(done_t == 3 + 2 * n, "R5 end time", done_t, 3 + 2 * n);
    chk(!extra, "R2 no re-ack while busy", extra, 0);
    chk(as_t == 1, "R3 as time", as_t, 1);
    if (rd) begin
      chk(ds_t == 1, "R3 read ds time", ds_t, 1);
      chk(rdata == d, "R7 rdata", rdata, d);
    end else begin
      chk(ds_t == ((n == 0) ? -1 : 3), "R4 write ds time", ds_t, (n == 0) ? -1 : 3);
    end
    chk(doe_ok, "R4 doe held", doe_ok, 1);
    chk(rel_ok, "R7 release at end", rel_ok, 1);
    chk(rw_ok, "R8 dir stable", rw_ok, 1);
    @(negedge clk);
    chk(!done, "R7 done one clock", done, 0);
    hs(stm, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic back_to_back;
    int acks, a2;
    bit gap_ok;
    req_rd = 1'b0; req_wdata = 32'hCAFE_0001; req_addr = 32'h2000_0000;
    hs(1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    req = 1'b1;
    do @(negedge clk); while (!ack);
    acks = 1; a2 = -1; gap_ok = 1;
    for (int t = 1; t <= 6; t++) begin
      @(negedge clk);
      if (t == 3 && bus_doe) gap_ok = 0;
      if (t == 4 && !bus_doe) gap_ok = 0;
      if (ack) begin
        acks++;
        if (a2 < 0) a2 = t;
        req = 1'b0;
      end
    end
    chk(a2 == 4, "R9 next T1 time", a2, 4);
    chk(gap_ok, "R9 doe turnaround", gap_ok, 1);
    chk(acks == 2, "R2 one ack per cycle", acks, 2);
    repeat (4) @(negedge clk);
    hs(1'b0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(as_n && ds_n, "R1 strobes in reset", {as_n, ds_n}, 2'b11);
    chk(!bus_doe && !ack && !done, "R1 idle outputs", {bus_doe, ack, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(as_n && ds_n && !bus_doe && !ack && !done, "R1 after reset",
        {as_n, ds_n, bus_doe, ack, done}, 5'b11000);
    for (int rd = 0; rd < 2; rd++)
      for (int stm = 0; stm < 2; stm++)
        for (int k = -1; k <= 6; k++)
          xfer(rd[0], stm[0], k);
    back_to_back();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule